// File: doc/BRIEF.md
# Packet-Filter VM Arithmetic Unit

This block is the arithmetic and logic engine of a 64-bit packet-filter virtual machine. Each operation takes a 4-bit operation code, a class bit that selects 64-bit or 32-bit operation, the destination register value, and a second operand. The second operand is either the source register value or a 32-bit immediate that the unit sign-extends to 64 bits. The unit returns the 64-bit value to write back to the destination register. Register storage, instruction decode and memory access are handled outside the block.

Most operations take one cycle. Unsigned divide and remainder use a restoring divider that produces one quotient bit per cycle, and `busy` is high while it runs. All results appear in a registered `result` with a one-cycle `done` strobe. A small state machine controls the sequence. In `IDLE` it waits for `start`. On an accepted `start` it moves to `DIVIDE` for a divide or remainder with a non-zero divisor, and to `FINISH` for any other operation. `DIVIDE` steps its counter and moves to `FINISH` after the last quotient bit. `FINISH` raises `done` for one cycle, then returns to `IDLE`, or it accepts a new `start` in that same cycle. The byte-order operation has its own swap unit that can work on 16, 32 or 64 bits.

Top module: `vm_alu`

## Requirements
- R1: The second operand is the immediate, sign-extended from bit 31, when `src_sel`=0, and `src_val` when `src_sel`=1.
- R2: With `wide`=1 the unit computes the following on all 64 bits, modulo 2^64: op 0 add, 1 subtract (dst minus operand), 2 multiply (low 64 bits), 4 OR, 5 AND, 0xA XOR, 8 negate dst (the second operand is ignored), 0xB move the second operand.
- R3: With `wide`=0 every operation except op 0xD uses only bits 31:0 of both operands as unsigned values, and the result is zero-extended to 64 bits.
- R4: Op 6 is a left shift, op 7 a logical right shift and op 0xC an arithmetic right shift of dst. The shift amount is the second operand masked to 6 bits when `wide`=1 and to 5 bits when `wide`=0.
- R5: Op 0xD converts the byte order of dst. An immediate of 16 selects 16 bits, 32 selects 32 bits, and any other value selects 64 bits. With `src_sel`=1 the bytes within that width are reversed. With `src_sel`=0 they are kept in place. Bits above the width are cleared in both cases, and `wide` has no effect.
- R6: Op 3 returns the unsigned quotient and op 9 the unsigned remainder of dst divided by the second operand, both taken at the class width.
- R7: If the divisor is zero at the class width, op 3 returns 0 and op 9 returns dst at the class width. `done` rises one cycle after `start` and `busy` stays low.
- R8: Every other operation raises `done` in the cycle after `start`, and `busy` stays low.
- R9: A divide or remainder with a non-zero divisor raises `busy` for 64 cycles (`wide`=1) or 32 cycles (`wide`=0). `done` rises in the cycle after `busy` falls. `busy` and `done` are never high together.
- R10: A `start` while `busy` is high is ignored. It does not change the running result or its timing.
- R11: Reset, which is asynchronous and active low, clears `busy`, `done` and `result` to 0, including during a divide.
- R12: While `busy` and `done` are both low, `result` holds the last value produced.
- R13: The unused codes 0xE and 0xF return dst at the class width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 = 64-bit class, 0 = 32-bit class |
| src_sel | input | 1 | 1 = source register operand, 0 = immediate operand (also the byte-order direction for op 0xD) |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Immediate, sign-extended inside the unit |
| busy | output | 1 | Divider running |
| done | output | 1 | One-cycle strobe: `result` is valid |
| result | output | 64 | Value to write back |

## Verification
A wrong state machine state shows at the ports right away. A stuck `DIVIDE` keeps `busy` high beyond the 32- or 64-cycle window. A missed `FINISH` means no `done` pulse at the expected cycle. Both are caught on the first operation by the latency check that runs alongside every result check. A wrong iteration count, or a wrong pre-shift of a 32-bit dividend, shows up as a wrong quotient or remainder when `done` rises. A corrupted `result` register while the unit is idle is caught on the next idle cycle by the hold check.

// File: rtl/vm_alu_pkg.sv
package vm_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'hA,
        OP_MOV  = 4'hB,
        OP_ARSH = 4'hC,
        OP_END  = 4'hD,
        OP_RSVE = 4'hE,
        OP_RSVF = 4'hF
    } alu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DIVIDE = 2'd1,
        ST_FINISH = 2'd2
    } alu_state_e;

    typedef enum logic [1:0] {
        SWAP_16   = 2'd0,
        SWAP_32   = 2'd1,
        SWAP_FULL = 2'd2
    } swap_width_e;

endpackage

// File: rtl/vm_alu_bswap.sv
module vm_alu_bswap
    import vm_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] value,
    input  logic            to_big,
    input  swap_width_e     width,
    output logic [XLEN-1:0] swapped
);
    localparam int NB = XLEN / 8;

    logic [XLEN-1:0] rev2;
    logic [XLEN-1:0] rev4;
    logic [XLEN-1:0] revn;
    logic [XLEN-1:0] mask16;
    logic [XLEN-1:0] mask32;

    assign mask16 = {{(XLEN-16){1'b0}}, {16{1'b1}}};
    assign mask32 = {{(XLEN-32){1'b0}}, {32{1'b1}}};

    // Byte lanes: reversed copies within 2, 4 and all bytes
    generate
        for (genvar i = 0; i < NB; i++) begin : g_lane
            if (i < 2) begin : g_in2
                assign rev2[8*i +: 8] = value[8*(1-i) +: 8];
            end else begin : g_out2
                assign rev2[8*i +: 8] = 8'h00;
            end
            if (i < 4) begin : g_in4
                assign rev4[8*i +: 8] = value[8*(3-i) +: 8];
            end else begin : g_out4
                assign rev4[8*i +: 8] = 8'h00;
            end
            assign revn[8*i +: 8] = value[8*(NB-1-i) +: 8];
        end
    endgenerate

    always_comb begin
        case (width)
            SWAP_16: swapped = to_big ? rev2 : (value & mask16);
            SWAP_32: swapped = to_big ? rev4 : (value & mask32);
            default: swapped = to_big ? revn : value;
        endcase
    end

endmodule

// File: rtl/vm_alu_logic.sv
module vm_alu_logic
    import vm_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [3:0]      op,
    input  logic            wide,
    input  logic            to_big,
    input  swap_width_e     swap_w,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);
    localparam int HALF = XLEN / 2;
    localparam int SHW  = $clog2(XLEN);

    logic [SHW-1:0]  sh_full;
    logic [SHW-2:0]  sh_half;
    logic [HALF-1:0] a_lo;
    logic [HALF-1:0] b_lo;
    logic [HALF-1:0] r_lo;
    logic [XLEN-1:0] r_full;
    logic [XLEN-1:0] swapped;

    assign sh_full = b[SHW-1:0];
    assign sh_half = b[SHW-2:0];
    assign a_lo    = a[HALF-1:0];
    assign b_lo    = b[HALF-1:0];

    vm_alu_bswap #(.XLEN(XLEN)) u_swap (
        .value   (a),
        .to_big  (to_big),
        .width   (swap_w),
        .swapped (swapped)
    );

    always_comb begin
        case (alu_op_e'(op))
            OP_ADD:  r_full = a + b;
            OP_SUB:  r_full = a - b;
            OP_MUL:  r_full = a * b;
            OP_OR:   r_full = a | b;
            OP_AND:  r_full = a & b;
            OP_XOR:  r_full = a ^ b;
            OP_NEG:  r_full = -a;
            OP_MOV:  r_full = b;
            OP_LSH:  r_full = a << sh_full;
            OP_RSH:  r_full = a >> sh_full;
            OP_ARSH: r_full = XLEN'($signed(a) >>> sh_full);
            default: r_full = a;
        endcase
    end

    always_comb begin
        case (alu_op_e'(op))
            OP_ADD:  r_lo = a_lo + b_lo;
            OP_SUB:  r_lo = a_lo - b_lo;
            OP_MUL:  r_lo = a_lo * b_lo;
            OP_OR:   r_lo = a_lo | b_lo;
            OP_AND:  r_lo = a_lo & b_lo;
            OP_XOR:  r_lo = a_lo ^ b_lo;
            OP_NEG:  r_lo = -a_lo;
            OP_MOV:  r_lo = b_lo;
            OP_LSH:  r_lo = a_lo << sh_half;
            OP_RSH:  r_lo = a_lo >> sh_half;
            OP_ARSH: r_lo = HALF'($signed(a_lo) >>> sh_half);
            default: r_lo = a_lo;
        endcase
    end

    always_comb begin
        if (alu_op_e'(op) == OP_END) begin
            y = swapped;
        end else if (wide) begin
            y = r_full;
        end else begin
            y = {{HALF{1'b0}}, r_lo};
        end
    end

endmodule

// File: rtl/vm_alu_div_step.sv
module vm_alu_div_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] rem_in,
    input  logic [XLEN-1:0] quo_in,
    input  logic [XLEN-1:0] divisor,
    output logic [XLEN-1:0] rem_out,
    output logic [XLEN-1:0] quo_out
);
    logic [XLEN:0] shifted;
    logic [XLEN:0] diff;
    logic          fits;

    assign shifted = {rem_in, quo_in[XLEN-1]};
    assign diff    = shifted - {1'b0, divisor};
    assign fits    = shifted >= {1'b0, divisor};
    assign rem_out = fits ? diff[XLEN-1:0] : shifted[XLEN-1:0];
    assign quo_out = {quo_in[XLEN-2:0], fits};

endmodule

// File: rtl/vm_alu.sv
module vm_alu
    import vm_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [3:0]      op,
    input  logic            wide,
    input  logic            src_sel,
    input  logic [XLEN-1:0] dst_val,
    input  logic [XLEN-1:0] src_val,
    input  logic [31:0]     imm,
    output logic            busy,
    output logic            done,
    output logic [XLEN-1:0] result
);
    localparam int HALF = XLEN / 2;
    localparam int CW   = $clog2(XLEN);

    alu_state_e      state_q, state_d;
    logic [XLEN-1:0] operand_b;
    logic [XLEN-1:0] dividend;
    logic [XLEN-1:0] divisor;
    logic            div_op;
    logic            div_zero;
    logic            accept;
    swap_width_e     swap_w;
    logic [XLEN-1:0] logic_y;

    logic [XLEN-1:0] rem_q, quo_q, dvs_q;
    logic [CW-1:0]   cnt_q;
    logic            is_mod_q;
    logic [XLEN-1:0] rem_n, quo_n;
    logic [XLEN-1:0] result_q;

    assign operand_b = src_sel ? src_val : {{(XLEN-32){imm[31]}}, imm};
    assign dividend  = wide ? dst_val   : {{HALF{1'b0}}, dst_val[HALF-1:0]};
    assign divisor   = wide ? operand_b : {{HALF{1'b0}}, operand_b[HALF-1:0]};
    assign div_op    = (alu_op_e'(op) == OP_DIV) || (alu_op_e'(op) == OP_MOD);
    assign div_zero  = (divisor == '0);
    assign accept    = start && (state_q != ST_DIVIDE);

    always_comb begin
        if (imm == 32'd16)      swap_w = SWAP_16;
        else if (imm == 32'd32) swap_w = SWAP_32;
        else                    swap_w = SWAP_FULL;
    end

    vm_alu_logic #(.XLEN(XLEN)) u_logic (
        .op     (op),
        .wide   (wide),
        .to_big (src_sel),
        .swap_w (swap_w),
        .a      (dst_val),
        .b      (operand_b),
        .y      (logic_y)
    );

    vm_alu_div_step #(.XLEN(XLEN)) u_step (
        .rem_in  (rem_q),
        .quo_in  (quo_q),
        .divisor (dvs_q),
        .rem_out (rem_n),
        .quo_out (quo_n)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH: begin
                if (accept && div_op && !div_zero) state_d = ST_DIVIDE;
                else if (accept)                   state_d = ST_FINISH;
                else                               state_d = ST_IDLE;
            end
            ST_DIVIDE: begin
                if (cnt_q == '0) state_d = ST_FINISH;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q    <= '0;
            quo_q    <= '0;
            dvs_q    <= '0;
            cnt_q    <= '0;
            is_mod_q <= 1'b0;
            result_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_FINISH: begin
                    if (accept) begin
                        if (div_op && !div_zero) begin
                            rem_q    <= '0;
                            quo_q    <= wide ? dividend : {dividend[HALF-1:0], {HALF{1'b0}}};
                            dvs_q    <= divisor;
                            cnt_q    <= wide ? CW'(XLEN-1) : CW'(HALF-1);
                            is_mod_q <= (alu_op_e'(op) == OP_MOD);
                        end else if (div_op) begin
                            result_q <= (alu_op_e'(op) == OP_DIV) ? '0 : dividend;
                        end else begin
                            result_q <= logic_y;
                        end
                    end
                end
                ST_DIVIDE: begin
                    rem_q <= rem_n;
                    quo_q <= quo_n;
                    cnt_q <= cnt_q - 1'b1;
                    if (cnt_q == '0) result_q <= is_mod_q ? rem_n : quo_n;
                end
                default: ;
            endcase
        end
    end

    assign busy   = (state_q == ST_DIVIDE);
    assign done   = (state_q == ST_FINISH);
    assign result = result_q;

endmodule

// File: rtl/vm_alu_chk.sv
module vm_alu_chk
    import vm_alu_pkg::*;
#(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [3:0]      op,
    input logic            wide,
    input logic            src_sel,
    input logic [XLEN-1:0] src_val,
    input logic [31:0]     imm,
    input logic            busy,
    input logic            done,
    input logic [XLEN-1:0] result
);
    logic [XLEN-1:0] opnd;
    logic            zero_dvs;
    logic            is_div;

    assign opnd     = src_sel ? src_val : {{(XLEN-32){imm[31]}}, imm};
    assign zero_dvs = wide ? (opnd == '0) : (opnd[31:0] == 32'd0);
    assign is_div   = (op == 4'h3) || (op == 4'h9);

    assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !is_div) |=> (done && !busy));

    assert_zero_divisor_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && is_div && zero_dvs) |=> (done && !busy));

    assert_div_enters_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && is_div && !zero_dvs) |=> busy);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> $stable(result));

endmodule

bind vm_alu vm_alu_chk #(.XLEN(XLEN)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .wide    (wide),
    .src_sel (src_sel),
    .src_val (src_val),
    .imm     (imm),
    .busy    (busy),
    .done    (done),
    .result  (result)
);

// File: tb/vm_alu_tb_top.sv
`timescale 1ns/1ps
module vm_alu_tb_top;

    typedef struct packed {
        logic [3:0]  op;
        logic        wide;
        logic        ssel;
        logic [63:0] dst;
        logic [63:0] src;
        logic [31:0] imm;
        logic [63:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 1'b1, 1'b1, 64'h0000_0001_FFFF_FFFF, 64'h1, 32'h0, 64'h0000_0002_0000_0000, 4'd2},  // R2 add
        '{4'h0, 1'b1, 1'b0, 64'h10, 64'h100, 32'hFFFF_FFFF, 64'hF, 4'd1},                           // R1 imm sext
        '{4'h0, 1'b0, 1'b1, 64'h1234_5678_FFFF_FFFF, 64'h2, 32'h0, 64'h1, 4'd3},                    // R3 add32
        '{4'h1, 1'b1, 1'b1, 64'h5, 64'h7, 32'h0, 64'hFFFF_FFFF_FFFF_FFFE, 4'd2},                    // R2 sub
        '{4'h1, 1'b0, 1'b0, 64'h5, 64'h0, 32'h7, 64'h0000_0000_FFFF_FFFE, 4'd3},                    // R3 sub32
        '{4'h2, 1'b1, 1'b1, 64'h1_0000_0001, 64'h1_0000_0001, 32'h0, 64'h2_0000_0001, 4'd2},        // R2 mul
        '{4'h2, 1'b0, 1'b0, 64'hFFFF_FFFF_0001_0000, 64'h0, 32'h0001_0001, 64'h0001_0000, 4'd3},    // R3 mul32
        '{4'h4, 1'b1, 1'b1, 64'hF0F0_0000_0000_000F, 64'h0F00_0000_0000_00F0, 32'h0, 64'hFFF0_0000_0000_00FF, 4'd2}, // R2 or
        '{4'h5, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FF00, 64'h0, 32'h8000_0F0F, 64'hFFFF_FFFF_8000_0F00, 4'd1}, // R1 and imm
        '{4'hA, 1'b1, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA, 64'hFFFF_FFFF_0000_0000, 32'h0, 64'h5555_5555_AAAA_AAAA, 4'd2}, // R2 xor
        '{4'h8, 1'b1, 1'b1, 64'h1, 64'h1234, 32'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd2},                 // R2 neg
        '{4'h8, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0001, 64'h0, 32'h55, 64'h0000_0000_FFFF_FFFF, 4'd3}, // R3 neg32
        '{4'hB, 1'b1, 1'b0, 64'hDEAD, 64'h77, 32'h8000_0000, 64'hFFFF_FFFF_8000_0000, 4'd1},        // R1 mov imm
        '{4'hB, 1'b0, 1'b0, 64'hDEAD, 64'h0, 32'h8000_0000, 64'h0000_0000_8000_0000, 4'd3},         // R3 mov32
        '{4'h6, 1'b1, 1'b1, 64'h1, 64'h44, 32'h0, 64'h10, 4'd4},                                    // R4 lsh mask6
        '{4'h6, 1'b0, 1'b1, 64'h8000_0000_0000_0001, 64'h24, 32'h0, 64'h10, 4'd4},                  // R4 lsh mask5
        '{4'h7, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 32'h4, 64'h0800_0000_0000_0000, 4'd4},  // R4 rsh
        '{4'hC, 1'b1, 1'b0, 64'h8000_0000_0000_0000, 64'h0, 32'h4, 64'hF800_0000_0000_0000, 4'd4},  // R4 arsh
        '{4'hC, 1'b0, 1'b0, 64'h0000_0000_8000_0000, 64'h0, 32'h21, 64'h0000_0000_C000_0000, 4'd4}, // R4 arsh32
        '{4'h7, 1'b0, 1'b0, 64'hFFFF_FFFF_8000_0000, 64'h0, 32'h1, 64'h0000_0000_4000_0000, 4'd4},  // R4 rsh32
        '{4'hD, 1'b1, 1'b1, 64'h1122_3344_5566_7788, 64'h0, 32'd16, 64'h8877, 4'd5},                // R5 swap16
        '{4'hD, 1'b1, 1'b1, 64'h1122_3344_5566_7788, 64'h0, 32'd32, 64'h8877_6655, 4'd5},           // R5 swap32
        '{4'hD, 1'b1, 1'b1, 64'h1122_3344_5566_7788, 64'h0, 32'd64, 64'h8877_6655_4433_2211, 4'd5}, // R5 swap64
        '{4'hD, 1'b1, 1'b0, 64'h1122_3344_5566_7788, 64'h0, 32'd16, 64'h7788, 4'd5},                // R5 keep16
        '{4'hD, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h0, 32'd32, 64'h5566_7788, 4'd5},           // R5 keep32
        '{4'hD, 1'b0, 1'b0, 64'h1122_3344_5566_7788, 64'h0, 32'd64, 64'h1122_3344_5566_7788, 4'd5}, // R5 keep64 class ignored
        '{4'hD, 1'b0, 1'b1, 64'h1122_3344_5566_7788, 64'h0, 32'd64, 64'h8877_6655_4433_2211, 4'd5}, // R5 swap64 class ignored
        '{4'hE, 1'b1, 1'b1, 64'h1234, 64'h5, 32'h0, 64'h1234, 4'd13},                               // R13
        '{4'hF, 1'b0, 1'b1, 64'hABCD_0000_0000_1234, 64'h5, 32'h0, 64'h1234, 4'd13},                // R13 narrow
        '{4'h3, 1'b1, 1'b1, 64'd100, 64'd7, 32'h0, 64'd14, 4'd6},                                   // R6 div
        '{4'h9, 1'b1, 1'b1, 64'd100, 64'd7, 32'h0, 64'd2, 4'd6},                                    // R6 mod
        '{4'h3, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 32'h0, 64'hFFFF_FFFF, 4'd6},  // R6 div large
        '{4'h9, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1_0000_0000, 32'h0, 64'hFFFF_FFFF, 4'd6},  // R6 mod large
        '{4'h3, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0064, 64'h0, 32'h7, 64'd14, 4'd6},                   // R6 div32
        '{4'h9, 1'b0, 1'b0, 64'hFFFF_FFFF_0000_0064, 64'h0, 32'hFFFF_FFF9, 64'h64, 4'd6},           // R6 mod32 unsigned
        '{4'h3, 1'b1, 1'b1, 64'd55, 64'h0, 32'h0, 64'h0, 4'd7},                                     // R7 div by 0
        '{4'h9, 1'b1, 1'b1, 64'd55, 64'h0, 32'h0, 64'd55, 4'd7},                                    // R7 mod by 0
        '{4'h9, 1'b0, 1'b1, 64'hFFFF_0000_0000_0037, 64'h0, 32'h0, 64'h37, 4'd7},                   // R7 mod32 by 0
        '{4'h3, 1'b0, 1'b1, 64'h99, 64'h1_0000_0000, 32'h0, 64'h0, 4'd7}                            // R7 low word 0
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = '0;
    logic        wide = 1'b0;
    logic        src_sel = 1'b0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic [31:0] imm = '0;
    logic        busy;
    logic        done;
    logic [63:0] result;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vm_alu #(.XLEN(64)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
        .src_sel(src_sel), .dst_val(dst_val), .src_val(src_val), .imm(imm),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    // Issue one operation and return result and cycles until done
    task automatic run_op(input vec_t v, output logic [63:0] res, output int lat);
        int guard;
        @(negedge clk);
        op = v.op; wide = v.wide; src_sel = v.ssel;
        dst_val = v.dst; src_val = v.src; imm = v.imm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            lat++;
            guard++;
        end
        res = result;
    endtask

    function automatic int exp_latency(input vec_t v);
        logic [63:0] b;
        logic        z;
        b = v.ssel ? v.src : {{32{v.imm[31]}}, v.imm};
        z = v.wide ? (b == 64'd0) : (b[31:0] == 32'd0);
        if ((v.op == 4'h3 || v.op == 4'h9) && !z) return v.wide ? 65 : 33;
        return 1;
    endfunction

    initial begin
        logic [63:0] res;
        int          lat;
        vec_t        v;

        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 busy", 64'(busy), 64'd0);
        check("R11 done", 64'(done), 64'd0);
        check("R11 result", result, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i], res, lat);
            check($sformatf("R%0d vec %0d result", VECS[i].req, i), res, VECS[i].exp);
            // R8 / R9 latency
            check($sformatf("R%0d vec %0d latency (R8/R9)", VECS[i].req, i),
                  64'(lat), 64'(exp_latency(VECS[i])));
        end

        // R10: start during divide ignored
        v = VECS[29];
        @(negedge clk);
        op = v.op; wide = v.wide; src_sel = v.ssel;
        dst_val = v.dst; src_val = v.src; imm = v.imm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (9) begin @(negedge clk); lat++; end
        check("R9 busy mid-divide", 64'(busy), 64'd1);
        op = 4'h0; dst_val = 64'h5; src_sel = 1'b1; src_val = 64'h5; start = 1'b1;
        @(negedge clk); lat++;
        start = 1'b0;
        while (!done && lat < 200) begin @(negedge clk); lat++; end
        check("R10 result after ignored start", result, 64'd14);
        check("R10 latency after ignored start", 64'(lat), 64'd65);

        // R12: result holds while idle
        repeat (5) @(negedge clk);
        check("R12 done low when idle", 64'(done), 64'd0);
        check("R12 result held", result, 64'd14);

        // R9: 32-bit divide busy window length
        v = VECS[33];
        @(negedge clk);
        op = v.op; wide = v.wide; src_sel = v.ssel;
        dst_val = v.dst; src_val = v.src; imm = v.imm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (busy && lat < 200) begin lat++; @(negedge clk); end
        check("R9 busy cycles narrow", 64'(lat), 64'd32);
        check("R9 done after busy", 64'(done), 64'd1);

        // R11: reset during divide
        v = VECS[31];
        @(negedge clk);
        op = v.op; wide = v.wide; src_sel = v.ssel;
        dst_val = v.dst; src_val = v.src; imm = v.imm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R11 busy after mid reset", 64'(busy), 64'd0);
        check("R11 done after mid reset", 64'(done), 64'd0);
        check("R11 result after mid reset", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        finish_run();
    end

endmodule